// File: doc/BRIEF.md
# Byte-Parity Registered Bus Transceiver

This block is a two-way data path between an A side and a B side. Each side carries a data word split into bytes, with one parity bit per byte. Each direction has its own storage element and its own output enable. The storage element can pass its input straight through, capture on a clock-qualified strobe, or hold a captured word.

In the A-to-B direction the block either computes new byte parity for the B side or checks the parity that arrives with the A word. The B-to-A direction always checks. One odd/even select sets the parity sense for every byte in both directions.

Each direction drives one error output. It is a pull-low request meant for an open-drain line, and it is asserted when either byte of that direction fails its check. The request is gated by that direction's output enable, so a direction with its outputs disabled never pulls the line. Several such requests can be combined on one wired-AND interrupt line.

Each direction's storage follows one of three modes, decoded every cycle from its latch-enable and capture-strobe inputs:
- Pass: latch enable high.
- Capture: latch enable low and strobe high.
- Hold: both low.

Any mode can follow any other on the next edge as those two inputs change. There is no further sequencing.

Top module: `bpx_transceiver`

## Requirements
- R1: After reset, with latch enable low and strobe low, both data outputs and both parity outputs read zero and neither error request is asserted.
- R2: While a direction's latch enable is high, its data and parity outputs equal that direction's inputs in the same cycle.
- R3: When latch enable is low and the strobe is high at a rising clock edge, the input word is captured and appears on the outputs after that edge.
- R4: When latch enable and strobe are both low, the stored word stays unchanged and the outputs ignore input changes.
- R5: With `gen_sel`=1, B parity bit k equals the XOR of data bits [8k+7:8k] (for the default 8-bit bytes) XOR `odd_sel`.
- R6: With `gen_sel`=0, the stored A parity bits pass unchanged to the B parity output. A mismatch in either byte asserts the A-to-B error request.
- R7: The B-to-A direction always checks. Its parity bits pass unchanged, and a mismatch in either byte asserts the B-to-A error request.
- R8: `odd_sel`=1 selects odd parity, where a byte plus its parity bit holds an odd number of ones. `odd_sel`=0 selects even parity.
- R9: An error request is asserted only while that direction's active-low output enable is 0.
- R10: Each drive output is high exactly while its direction's active-low output enable is 0.
- R11: The two directions store and check independently. Stimulus on one direction leaves the other's outputs and error request unchanged.
- R12: In generate mode the A-to-B error request is never asserted, whatever parity arrives on the A side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears storage |
| odd_sel | input | 1 | 1 = odd parity, 0 = even, both directions |
| gen_sel | input | 1 | A-to-B: 1 = generate parity, 0 = check |
| a_data_in | input | 16 | A-side data into A-to-B path |
| a_par_in | input | 2 | A-side byte parity into A-to-B path |
| ab_le | input | 1 | A-to-B latch enable (pass when high) |
| ab_cap | input | 1 | A-to-B capture strobe |
| ab_oe_n | input | 1 | A-to-B active-low output enable |
| b_data_out | output | 16 | B-side data out |
| b_par_out | output | 2 | B-side byte parity out |
| b_drive | output | 1 | B-side outputs driven |
| ab_flag_pull | output | 1 | A-to-B error, pull-low request |
| b_data_in | input | 16 | B-side data into B-to-A path |
| b_par_in | input | 2 | B-side byte parity into B-to-A path |
| ba_le | input | 1 | B-to-A latch enable |
| ba_cap | input | 1 | B-to-A capture strobe |
| ba_oe_n | input | 1 | B-to-A active-low output enable |
| a_data_out | output | 16 | A-side data out |
| a_par_out | output | 2 | A-side byte parity out |
| a_drive | output | 1 | A-side outputs driven |
| ba_flag_pull | output | 1 | B-to-A error, pull-low request |

## Verification
The bench builds the block with its default parameters: 8-bit bytes and two bytes per word. Two bytes are enough to corrupt each byte's parity on its own and confirm that either one alone raises the shared request. Eight-bit bytes keep hand-computed parity values easy to follow. Under both parity senses, the bench drives words with known one-counts through pass, capture and hold modes. It models the open-drain line as a wired-AND of the two requests.

// File: rtl/bpx_pkg.sv
package bpx_pkg;

    typedef enum logic [1:0] {
        SM_HOLD    = 2'd0,
        SM_CAPTURE = 2'd1,
        SM_PASS    = 2'd2
    } stor_mode_t;

    function automatic stor_mode_t decode_mode(input logic le, input logic cap);
        if (le)       return SM_PASS;
        else if (cap) return SM_CAPTURE;
        else          return SM_HOLD;
    endfunction

endpackage

// File: rtl/bpx_store.sv
module bpx_store
    import bpx_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         cap,
    input  logic [W-1:0] d,
    output logic [W-1:0] q_out
);

    stor_mode_t   mode;
    logic [W-1:0] held;

    always_comb begin
        mode = decode_mode(le, cap);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else begin
            unique case (mode)
                SM_PASS:    held <= d;
                SM_CAPTURE: held <= d;
                SM_HOLD:    held <= held;
                default:    held <= held;
            endcase
        end
    end

    always_comb begin
        q_out = (mode == SM_PASS) ? d : held;
    end

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !cap) |=> $stable(held));

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && cap) |=> (held == $past(d)));

endmodule

// File: rtl/bpx_byte_parity.sv
module bpx_byte_parity #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2,
    localparam int DW = BYTE_W * NBYTES
) (
    input  logic [DW-1:0]     data,
    input  logic [NBYTES-1:0] par_in,
    input  logic              odd_sel,
    output logic [NBYTES-1:0] par_gen,
    output logic [NBYTES-1:0] mism
);

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        logic red;
        assign red        = ^data[k*BYTE_W +: BYTE_W];
        assign par_gen[k] = red ^ odd_sel;
        assign mism[k]    = red ^ par_in[k] ^ odd_sel;
    end

endmodule

// File: rtl/bpx_transceiver.sv
module bpx_transceiver #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2,
    localparam int DW = BYTE_W * NBYTES,
    localparam int SW = DW + NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              odd_sel,
    input  logic              gen_sel,
    input  logic [DW-1:0]     a_data_in,
    input  logic [NBYTES-1:0] a_par_in,
    input  logic              ab_le,
    input  logic              ab_cap,
    input  logic              ab_oe_n,
    output logic [DW-1:0]     b_data_out,
    output logic [NBYTES-1:0] b_par_out,
    output logic              b_drive,
    output logic              ab_flag_pull,
    input  logic [DW-1:0]     b_data_in,
    input  logic [NBYTES-1:0] b_par_in,
    input  logic              ba_le,
    input  logic              ba_cap,
    input  logic              ba_oe_n,
    output logic [DW-1:0]     a_data_out,
    output logic [NBYTES-1:0] a_par_out,
    output logic              a_drive,
    output logic              ba_flag_pull
);

    logic [SW-1:0]     ab_word, ba_word;
    logic [NBYTES-1:0] ab_gen, ab_mism, ba_gen, ba_mism;

    bpx_store #(.W(SW)) u_store_ab (
        .clk(clk), .rst_n(rst_n), .le(ab_le), .cap(ab_cap),
        .d({a_par_in, a_data_in}), .q_out(ab_word)
    );

    bpx_store #(.W(SW)) u_store_ba (
        .clk(clk), .rst_n(rst_n), .le(ba_le), .cap(ba_cap),
        .d({b_par_in, b_data_in}), .q_out(ba_word)
    );

    bpx_byte_parity #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_par_ab (
        .data(ab_word[DW-1:0]), .par_in(ab_word[SW-1:DW]), .odd_sel(odd_sel),
        .par_gen(ab_gen), .mism(ab_mism)
    );

    bpx_byte_parity #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_par_ba (
        .data(ba_word[DW-1:0]), .par_in(ba_word[SW-1:DW]), .odd_sel(odd_sel),
        .par_gen(ba_gen), .mism(ba_mism)
    );

    always_comb begin
        b_data_out   = ab_word[DW-1:0];
        b_par_out    = gen_sel ? ab_gen : ab_word[SW-1:DW];
        b_drive      = ~ab_oe_n;
        ab_flag_pull = ~ab_oe_n & ~gen_sel & (|ab_mism);
        a_data_out   = ba_word[DW-1:0];
        a_par_out    = ba_word[SW-1:DW];
        a_drive      = ~ba_oe_n;
        ba_flag_pull = ~ba_oe_n & (|ba_mism);
    end

    assert_ab_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ab_flag_pull |-> !ab_oe_n);

    assert_ba_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ba_flag_pull |-> !ba_oe_n);

    assert_gen_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        gen_sel |-> !ab_flag_pull);

    for (genvar k = 0; k < NBYTES; k++) begin : g_chk
        assert_gen_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
            gen_sel |-> (((^b_data_out[k*BYTE_W +: BYTE_W]) ^ b_par_out[k]) == odd_sel));
    end

endmodule

// File: tb/bpx_transceiver_test.sv
module bpx_transceiver_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        odd_sel = 1'b0, gen_sel = 1'b0;
    logic [15:0] a_data_in = '0, b_data_in = '0;
    logic [1:0]  a_par_in = '0, b_par_in = '0;
    logic        ab_le = 1'b0, ab_cap = 1'b0, ab_oe_n = 1'b1;
    logic        ba_le = 1'b0, ba_cap = 1'b0, ba_oe_n = 1'b1;
    logic [15:0] b_data_out, a_data_out;
    logic [1:0]  b_par_out, a_par_out;
    logic        b_drive, a_drive, ab_flag_pull, ba_flag_pull;
    logic        irq_line_n;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    assign irq_line_n = ~(ab_flag_pull | ba_flag_pull);

    bpx_transceiver uut (
        .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel), .gen_sel(gen_sel),
        .a_data_in(a_data_in), .a_par_in(a_par_in), .ab_le(ab_le), .ab_cap(ab_cap),
        .ab_oe_n(ab_oe_n), .b_data_out(b_data_out), .b_par_out(b_par_out),
        .b_drive(b_drive), .ab_flag_pull(ab_flag_pull),
        .b_data_in(b_data_in), .b_par_in(b_par_in), .ba_le(ba_le), .ba_cap(ba_cap),
        .ba_oe_n(ba_oe_n), .a_data_out(a_data_out), .a_par_out(a_par_out),
        .a_drive(a_drive), .ba_flag_pull(ba_flag_pull)
    );

    function automatic logic [1:0] mkpar(input logic [15:0] d, input logic odd);
        return {(^d[15:8]) ^ odd, (^d[7:0]) ^ odd};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        a_data_in = 16'hFFFF;
        b_data_in = 16'hFFFF;
        settle();
        check("R1 b data", b_data_out, 0);
        check("R1 a data", a_data_out, 0);
        check("R1 parity", {a_par_out, b_par_out}, 0);
        check("R1 flags", {ab_flag_pull, ba_flag_pull}, 0);
    endtask

    task automatic t_transparent();
        odd_sel = 1'b0; gen_sel = 1'b0; ab_oe_n = 1'b1; ba_oe_n = 1'b1;
        ab_le = 1'b1; a_data_in = 16'h1234; a_par_in = 2'b10;
        #1;
        check("R2 ab data", b_data_out, 16'h1234);
        check("R2 ab par", b_par_out, 2'b10);
        check("R11 ba untouched", a_data_out, 0);
        ba_le = 1'b1; b_data_in = 16'hBEEF; b_par_in = 2'b01;
        #1;
        check("R2 ba data", a_data_out, 16'hBEEF);
        check("R2 ba par", a_par_out, 2'b01);
        check("R10 drives off", {a_drive, b_drive}, 0);
    endtask

    task automatic t_capture_hold();
        @(negedge clk);
        ab_le = 1'b0; ab_cap = 1'b1; a_data_in = 16'hA55A; a_par_in = 2'b11;
        @(negedge clk);
        ab_cap = 1'b0; a_data_in = 16'h0F0F; a_par_in = 2'b00;
        #1;
        check("R3 captured", b_data_out, 16'hA55A);
        check("R3 captured par", b_par_out, 2'b11);
        repeat (3) @(posedge clk);
        a_data_in = 16'h7777;
        settle();
        check("R4 held", b_data_out, 16'hA55A);
        ba_le = 1'b0;
        b_data_in = 16'h1111;
        settle();
        check("R11 ab unaffected by ba", b_data_out, 16'hA55A);
    endtask

    task automatic t_generate();
        gen_sel = 1'b1; ab_oe_n = 1'b0; ab_le = 1'b1;
        a_data_in = 16'h0301; a_par_in = 2'b11;
        odd_sel = 1'b0;
        #1;
        check("R5 even gen", b_par_out, mkpar(16'h0301, 1'b0));
        check("R12 no flag", ab_flag_pull, 0);
        odd_sel = 1'b1;
        #1;
        check("R8 odd gen", b_par_out, 2'b10);
        check("R12 no flag odd", ab_flag_pull, 0);
        check("R10 b drive", b_drive, 1);
    endtask

    task automatic t_check_ab();
        gen_sel = 1'b0; odd_sel = 1'b0; ab_oe_n = 1'b0; ab_le = 1'b1;
        a_data_in = 16'h0701; a_par_in = mkpar(16'h0701, 1'b0);
        #1;
        check("R6 pass par", b_par_out, 2'b11);
        check("R6 good no flag", ab_flag_pull, 0);
        a_par_in = 2'b10;
        #1;
        check("R6 byte0 bad", ab_flag_pull, 1);
        check("R6 line low", irq_line_n, 0);
        a_par_in = 2'b01;
        #1;
        check("R6 byte1 bad", ab_flag_pull, 1);
        ab_oe_n = 1'b1;
        #1;
        check("R9 gated", ab_flag_pull, 0);
        check("R9 line high", irq_line_n, 1);
        ab_oe_n = 1'b0;
        odd_sel = 1'b1; a_par_in = mkpar(16'h0701, 1'b1);
        #1;
        check("R8 odd good", ab_flag_pull, 0);
        odd_sel = 1'b0;
        #1;
        check("R8 sense flip flags", ab_flag_pull, 1);
        ab_oe_n = 1'b1;
    endtask

    task automatic t_check_ba();
        gen_sel = 1'b1; odd_sel = 1'b0; ba_oe_n = 1'b0; ba_le = 1'b1;
        b_data_in = 16'h8001; b_par_in = 2'b11;
        #1;
        check("R7 pass par", a_par_out, 2'b11);
        check("R7 good", ba_flag_pull, 0);
        b_par_in = 2'b01;
        #1;
        check("R7 bad byte1 in gen mode", ba_flag_pull, 1);
        check("R11 ab quiet", ab_flag_pull, 0);
        check("R10 a drive", a_drive, 1);
        ba_oe_n = 1'b1;
        #1;
        check("R9 ba gated", ba_flag_pull, 0);
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_capture_hold();
        t_generate();
        t_check_ab();
        t_check_ba();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule